// File: doc/BRIEF.md
# USB Host Frame Interval Timer

This block keeps the frame clock of a USB host controller. It counts bit-times, which arrive as a one-cycle strobe. A 14-bit counter runs down from a programmable interval. When the counter reaches zero, the next bit-time starts a new frame. At that point the block reloads the counter, raises a one-cycle start-of-frame pulse and advances a 16-bit frame number. It also reloads a per-frame packet budget that the transfer scheduler spends as data bits go out.

Software programs the frame through a 32-bit interval word. The word holds the interval, the largest-packet budget and a toggle bit. Each frame reload copies that toggle into the read-only remaining word. Software can therefore see when a changed interval has reached the frame boundary.

A controller-reset request puts the interval back to its nominal 11999 and halts the counter. An enter-operational event reloads the counter and starts it running.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the block is in this state:
  - the interval word reads 0x00002EDF (toggle 0, packet budget 0, interval 11999);
  - the remaining word reads 0;
  - the frame number is 0;
  - sof_pulse and budget_left are 0;
  - the counter is idle.
- R2: enter_oper loads the remaining count from the interval field and starts the counter. It raises no start-of-frame pulse.
- R3: While the counter runs and the remaining count is non-zero, each bit_strobe lowers the count by one. While the counter is idle, bit_strobe changes nothing.
- R4: A bit_strobe at remaining count 0 while running does three things in the next cycle:
  - the remaining count becomes the interval field;
  - remaining-word bit 31 takes interval-word bit 31;
  - sof_pulse is high for that one cycle.
- R5: The frame number rises by one, modulo 65536, in the same cycle that sof_pulse is high. fnum_wr_en loads fnum_wr_data, except in a cycle that starts a frame, where the increment wins.
- R6: The interval word is laid out as follows:
  - bit 31 is the toggle;
  - bits 30:16 are the largest-packet budget;
  - bits 15:14 read 0;
  - bits 13:0 are the interval.
  A write does not shorten the frame in progress. The new interval takes effect at the next reload.
- R7: The remaining word has the toggle at bit 31 and the count at bits 13:0. All other bits read 0.
- R8: hc_reset_req sets the interval field to 11999 and leaves the counter idle. It takes priority over an interval write and over enter_oper in the same cycle, and that write is dropped.
- R9: Each frame start (a reload or enter_oper) loads budget_left from the largest-packet field.
- R10: data_strobe subtracts data_bits from budget_left and stops at 0. In a cycle that loads the budget, data_strobe has no effect.
- R11: pkt_fits is high exactly when pkt_len is less than or equal to budget_left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_strobe | input | 1 | One-cycle bit-time strobe |
| hc_reset_req | input | 1 | Controller-reset request |
| enter_oper | input | 1 | Enter-operational event |
| intv_wr_en | input | 1 | Interval word write enable |
| intv_wr_data | input | 32 | Interval word write data |
| intv_rd_data | output | 32 | Interval word read data |
| rem_rd_data | output | 32 | Remaining word read data |
| fnum_wr_en | input | 1 | Frame number write enable |
| fnum_wr_data | input | 16 | Frame number write data |
| fnum_rd_data | output | 16 | Frame number |
| sof_pulse | output | 1 | One-cycle start-of-frame pulse |
| data_strobe | input | 1 | Data bits spent this cycle |
| data_bits | input | 15 | Number of bits spent |
| pkt_len | input | 15 | Length of the packet being considered |
| pkt_fits | output | 1 | Packet still fits in this frame |
| budget_left | output | 15 | Remaining packet budget in bits |

## Verification
The assertions assume that reset is held for at least one clock before the counter runs. They also assume that the strobes are single-cycle pulses sampled on the rising edge. The bench meets this by changing inputs only at the falling edge and keeping every strobe one cycle wide. It programs intervals of at most 30 bit-times, so that many frame wraps, toggle copies and budget reloads occur within the run.

// File: rtl/frame_timer_pkg.sv
// Package: shared constants and word-packing helpers for the frame timer.
// Assumes a 14-bit interval and a 15-bit packet budget, so the words pack to 32 bits.
package frame_timer_pkg;
    localparam int unsigned FT_CNT_W  = 14;
    localparam int unsigned FT_PKT_W  = 15;
    localparam int unsigned FT_FNUM_W = 16;
    localparam int unsigned FT_NOMINAL_INTERVAL = 11999;

    // Pack the interval word: toggle, budget, two zero bits, interval.
    function automatic logic [31:0] pack_interval(input logic tog,
                                                  input logic [FT_PKT_W-1:0] pkt,
                                                  input logic [FT_CNT_W-1:0] ivl);
        return {tog, pkt, 2'b00, ivl};
    endfunction

    // Pack the remaining word: toggle, zero filler, count.
    function automatic logic [31:0] pack_remaining(input logic tog,
                                                   input logic [FT_CNT_W-1:0] cnt);
        return {tog, {(31-FT_CNT_W){1'b0}}, cnt};
    endfunction
endpackage

// File: rtl/frame_interval_reg.sv
// Module: holds the software-programmed interval, the largest-packet value and the toggle.
// Assumes: a controller-reset request takes priority over a write in the same cycle.
module frame_interval_reg #(
    parameter int unsigned CNT_W   = 14,
    parameter int unsigned PKT_W   = 15,
    parameter int unsigned NOMINAL = 11999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hc_reset_req,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [CNT_W-1:0] interval,
    output logic [PKT_W-1:0] pkt_max,
    output logic             toggle
);
    localparam logic [CNT_W-1:0] NOM_VAL = CNT_W'(NOMINAL);

    // Register update: reset request restores the nominal interval, else a write loads all fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval <= NOM_VAL;
            pkt_max  <= '0;
            toggle   <= 1'b0;
        end else if (hc_reset_req) begin
            interval <= NOM_VAL;
        end else if (wr_en) begin
            toggle   <= wr_data[31];
            pkt_max  <= wr_data[16 +: PKT_W];
            interval <= wr_data[CNT_W-1:0];
        end
    end

    AST_NOMINAL_AFTER_HC_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        hc_reset_req |=> interval == NOM_VAL); // R8
endmodule

// File: rtl/frame_countdown.sv
// Module: counts down the bit-times left in the frame, reloads at zero and emits the SOF pulse.
// Assumes: bit_strobe is one cycle wide. Priority is reset request, then enter-operational, then reload.
module frame_countdown #(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_strobe,
    input  logic             hc_reset_req,
    input  logic             enter_oper,
    input  logic [CNT_W-1:0] interval,
    input  logic             ivl_toggle,
    output logic [CNT_W-1:0] remaining,
    output logic             rem_toggle,
    output logic             reload,
    output logic             frame_start,
    output logic             sof
);
    logic running;

    // Reload decision: a strobe at zero while running and not overridden.
    always_comb begin
        reload      = running && bit_strobe && (remaining == '0) && !hc_reset_req && !enter_oper;
        frame_start = reload || (enter_oper && !hc_reset_req);
    end

    // Counter state: halt on reset request, start on enter, reload at zero, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining  <= '0;
            rem_toggle <= 1'b0;
            running    <= 1'b0;
            sof        <= 1'b0;
        end else begin
            sof <= reload;
            if (hc_reset_req) begin
                running <= 1'b0;
            end else if (enter_oper) begin
                remaining <= interval;
                running   <= 1'b1;
            end else if (reload) begin
                remaining  <= interval;
                rem_toggle <= ivl_toggle;
            end else if (running && bit_strobe) begin
                remaining <= remaining - 1'b1;
            end
        end
    end

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (running && bit_strobe && remaining != '0 && !hc_reset_req && !enter_oper)
        |=> remaining == $past(remaining) - 1'b1); // R3
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (remaining == $past(interval)) && sof); // R4
    AST_TOGGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> rem_toggle == $past(ivl_toggle)); // R4
    AST_ENTER_NO_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_oper && !hc_reset_req) |=> !sof && remaining == $past(interval)); // R2
endmodule

// File: rtl/frame_number_ctr.sv
// Module: 16-bit frame number that advances at each frame reload.
// Assumes: the increment wins over a software write in the same cycle.
module frame_number_ctr #(
    parameter int unsigned FNUM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              wr_en,
    input  logic [FNUM_W-1:0] wr_data,
    output logic [FNUM_W-1:0] fnum
);
    // Frame number update: increment on reload, else load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)     fnum <= '0;
        else if (inc)   fnum <= fnum + 1'b1;
        else if (wr_en) fnum <= wr_data;
    end

    AST_FNUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> fnum == $past(fnum) + 1'b1); // R5
endmodule

// File: rtl/packet_budget.sv
// Module: per-frame budget of data bits. Loaded at each frame start, spent down and saturating at zero.
// Assumes: a load in the same cycle as a data strobe discards the strobe.
module packet_budget #(
    parameter int unsigned PKT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PKT_W-1:0] load_val,
    input  logic             data_strobe,
    input  logic [PKT_W-1:0] data_bits,
    input  logic [PKT_W-1:0] pkt_len,
    output logic [PKT_W-1:0] budget,
    output logic             fits
);
    // Fit flag: the packet fits while its length is within the budget.
    always_comb fits = (pkt_len <= budget);

    // Budget update: load at frame start, else subtract with a floor at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                budget <= '0;
        else if (load)             budget <= load_val;
        else if (data_strobe)      budget <= (budget >= data_bits) ? budget - data_bits : '0;
    end

    AST_BUDGET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> budget == $past(load_val)); // R9
    AST_BUDGET_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_strobe && !load) |=> budget <= $past(budget)); // R10
endmodule

// File: rtl/usb_frame_timer.sv
// Module: top of the USB host frame timer. Wires the interval register, countdown,
// frame number and packet budget together and packs the 32-bit read words.
// Assumes: PKT_W is 15 and CNT_W is at most 14, so the interval word packs into 32 bits.
module usb_frame_timer
    import frame_timer_pkg::*;
#(
    parameter int unsigned CNT_W   = FT_CNT_W,
    parameter int unsigned PKT_W   = FT_PKT_W,
    parameter int unsigned FNUM_W  = FT_FNUM_W,
    parameter int unsigned NOMINAL = FT_NOMINAL_INTERVAL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_strobe,
    input  logic              hc_reset_req,
    input  logic              enter_oper,
    input  logic              intv_wr_en,
    input  logic [31:0]       intv_wr_data,
    output logic [31:0]       intv_rd_data,
    output logic [31:0]       rem_rd_data,
    input  logic              fnum_wr_en,
    input  logic [FNUM_W-1:0] fnum_wr_data,
    output logic [FNUM_W-1:0] fnum_rd_data,
    output logic              sof_pulse,
    input  logic              data_strobe,
    input  logic [PKT_W-1:0]  data_bits,
    input  logic [PKT_W-1:0]  pkt_len,
    output logic              pkt_fits,
    output logic [PKT_W-1:0]  budget_left
);
    localparam int unsigned IVL_GAP = 16 - CNT_W;
    localparam int unsigned REM_GAP = 31 - CNT_W;

    logic [CNT_W-1:0] interval, remaining;
    logic [PKT_W-1:0] pkt_max;
    logic             ivl_toggle, rem_toggle, reload, frame_start;

    frame_interval_reg #(.CNT_W(CNT_W), .PKT_W(PKT_W), .NOMINAL(NOMINAL)) u_ivl (
        .clk(clk), .rst_n(rst_n), .hc_reset_req(hc_reset_req),
        .wr_en(intv_wr_en), .wr_data(intv_wr_data),
        .interval(interval), .pkt_max(pkt_max), .toggle(ivl_toggle));

    frame_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe),
        .hc_reset_req(hc_reset_req), .enter_oper(enter_oper),
        .interval(interval), .ivl_toggle(ivl_toggle),
        .remaining(remaining), .rem_toggle(rem_toggle),
        .reload(reload), .frame_start(frame_start), .sof(sof_pulse));

    frame_number_ctr #(.FNUM_W(FNUM_W)) u_fnum (
        .clk(clk), .rst_n(rst_n), .inc(reload),
        .wr_en(fnum_wr_en), .wr_data(fnum_wr_data), .fnum(fnum_rd_data));

    packet_budget #(.PKT_W(PKT_W)) u_bud (
        .clk(clk), .rst_n(rst_n), .load(frame_start), .load_val(pkt_max),
        .data_strobe(data_strobe), .data_bits(data_bits), .pkt_len(pkt_len),
        .budget(budget_left), .fits(pkt_fits));

    // Read word packing: fields at fixed positions, unused bits zero.
    always_comb begin
        intv_rd_data = {ivl_toggle, pkt_max, {IVL_GAP{1'b0}}, interval};
        rem_rd_data  = {rem_toggle, {REM_GAP{1'b0}}, remaining};
    end

    AST_FNUM_WITH_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sof_pulse) |-> fnum_rd_data == $past(fnum_rd_data) + 1'b1); // R5
    AST_BUDGET_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> budget_left == $past(intv_rd_data[16 +: PKT_W])); // R9
endmodule

// File: tb/usb_frame_timer_tb.sv
module usb_frame_timer_tb;
    import frame_timer_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int NOM = 11999;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bs = 0, hcr = 0, eo = 0, iw = 0, fw = 0, ds = 0;
    logic [31:0] iw_data = '0;
    logic [15:0] fw_data = '0;
    logic [14:0] dbits = '0, plen = '0;

    logic [31:0] intv_rd, rem_rd;
    logic [15:0] fnum;
    logic sof, fits;
    logic [14:0] budget;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_frame_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bs), .hc_reset_req(hcr), .enter_oper(eo),
        .intv_wr_en(iw), .intv_wr_data(iw_data), .intv_rd_data(intv_rd),
        .rem_rd_data(rem_rd), .fnum_wr_en(fw), .fnum_wr_data(fw_data),
        .fnum_rd_data(fnum), .sof_pulse(sof), .data_strobe(ds), .data_bits(dbits),
        .pkt_len(plen), .pkt_fits(fits), .budget_left(budget));

    // Reference model state, built from the requirements.
    logic [13:0] m_ivl, m_rem;
    logic [14:0] m_pkt, m_bud;
    logic        m_tog, m_rtog, m_run, m_sof;
    logic [15:0] m_fnum;

    always @(posedge clk) begin
        logic rl, fs;
        if (!rst_n) begin
            m_ivl = 14'(NOM); m_pkt = '0; m_tog = 0; m_rem = '0; m_rtog = 0;
            m_run = 0; m_sof = 0; m_fnum = '0; m_bud = '0;
        end else begin
            rl = m_run && bs && m_rem == 0 && !hcr && !eo;
            fs = rl || (eo && !hcr);
            if (fs) m_bud = m_pkt;
            else if (ds) m_bud = (m_bud >= dbits) ? m_bud - dbits : '0;
            if (rl) m_fnum = m_fnum + 1;
            else if (fw) m_fnum = fw_data;
            if (hcr) m_run = 0;
            else if (eo) begin m_rem = m_ivl; m_run = 1; end
            else if (rl) begin m_rem = m_ivl; m_rtog = m_tog; end
            else if (m_run && bs) m_rem = m_rem - 1;
            m_sof = rl;
            if (hcr) m_ivl = 14'(NOM);
            else if (iw) begin m_tog = iw_data[31]; m_pkt = iw_data[30:16]; m_ivl = iw_data[13:0]; end
        end
    end

    function automatic logic [31:0] exp_intv();
        return pack_interval(m_tog, m_pkt, m_ivl);
    endfunction
    function automatic logic [31:0] exp_rem();
        return pack_remaining(m_rtog, m_rem);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_all(input string rem_tag);
        chk("R6 interval word", intv_rd, exp_intv());
        chk(rem_tag, rem_rd, exp_rem());
        chk("R5 frame number", {16'd0, fnum}, {16'd0, m_fnum});
        chk("R4 sof pulse", {31'd0, sof}, {31'd0, m_sof});
        chk("R10 budget", {17'd0, budget}, {17'd0, m_bud});
        chk("R11 fits", {31'd0, fits}, {31'd0, (plen <= m_bud)});
    endtask

    // One clock step: inputs were set at the falling edge; check at the next falling edge, then clear strobes.
    task automatic tick(input string rem_tag);
        @(posedge clk);
        @(negedge clk);
        compare_all(rem_tag);
        bs = 0; hcr = 0; eo = 0; iw = 0; fw = 0; ds = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: literal reset values
        chk("R1 interval reset", intv_rd, 32'h0000_2EDF);
        chk("R1 remaining reset", rem_rd, 32'h0);
        chk("R1 fnum reset", {16'd0, fnum}, 32'h0);
        chk("R1 sof/budget reset", {16'd0, sof, budget}, 32'h0);
        // R3: strobes while idle change nothing
        for (int i = 0; i < 4; i++) begin bs = 1; tick("R3 idle strobe"); end
        chk("R3 idle remaining", rem_rd, 32'h0);
        // R6: field layout; bits 15:14 dropped
        iw = 1; iw_data = {1'b1, 15'd100, 2'b11, 14'd3}; tick("R7 remaining word");
        chk("R6 layout", intv_rd, 32'h8064_0003);
        // R2: enter loads remaining, R9 loads budget, no SOF
        eo = 1; tick("R2 enter");
        chk("R2 remaining after enter", rem_rd, 32'h3);
        chk("R9 budget after enter", {17'd0, budget}, 32'd100);
        chk("R2 no sof on enter", {31'd0, sof}, 32'd0);
        // R3 count down 3..0
        for (int i = 0; i < 3; i++) begin bs = 1; tick("R3 count down"); end
        chk("R3 reached zero", rem_rd, 32'h0);
        // R6: a write mid-frame takes effect only at the next reload
        iw = 1; iw_data = {1'b1, 15'd100, 2'b00, 14'd5}; tick("R6 deferred");
        chk("R6 current frame kept", rem_rd, 32'h0);
        // R4: reload with toggle copy and SOF
        bs = 1; tick("R4 reload");
        chk("R4 reload word", rem_rd, 32'h8000_0005);
        chk("R4 sof high", {31'd0, sof}, 32'd1);
        chk("R5 fnum with sof", {16'd0, fnum}, 32'd1);
        tick("R4 single pulse");
        chk("R4 sof one cycle", {31'd0, sof}, 32'd0);
        // R10: subtract and saturate; R11 fit flag
        ds = 1; dbits = 15'd60; tick("R10 spend");
        chk("R10 after spend", {17'd0, budget}, 32'd40);
        plen = 15'd40; #1 chk("R11 equal fits", {31'd0, fits}, 32'd1);
        plen = 15'd41; #1 chk("R11 over not fit", {31'd0, fits}, 32'd0);
        ds = 1; dbits = 15'd50; tick("R10 saturate");
        chk("R10 floor zero", {17'd0, budget}, 32'd0);
        // R8: reset request beats write and enter
        hcr = 1; iw = 1; iw_data = 32'h0000_0007; eo = 1; tick("R8 hc reset");
        chk("R8 nominal", intv_rd[13:0], 32'(NOM));
        for (int i = 0; i < 8; i++) begin bs = 1; tick("R8 halted"); end
        // R5: wrap from 0xFFFF; the increment wins over a simultaneous write
        iw = 1; iw_data = {1'b0, 15'd20, 2'b00, 14'd1}; tick("R6 write");
        eo = 1; fw = 1; fw_data = 16'hFFFF; tick("R2 enter");
        bs = 1; tick("R3 count");
        bs = 1; fw = 1; fw_data = 16'h1234; tick("R5 wrap");
        chk("R5 wrap to zero", {16'd0, fnum}, 32'd0);
        // Random phase
        iw = 1; iw_data = {1'b1, 15'd500, 2'b00, 14'd12}; tick("R6 write");
        eo = 1; tick("R2 enter");
        for (int i = 0; i < 6000; i++) begin
            bs = ($urandom_range(0, 1) == 1);
            ds = ($urandom_range(0, 3) == 0);
            dbits = 15'($urandom_range(0, 200));
            plen = 15'($urandom_range(0, 600));
            if ($urandom_range(0, 39) == 0) begin
                iw = 1;
                iw_data = {1'($urandom_range(0, 1)), 15'($urandom_range(0, 900)), 2'($urandom_range(0, 3)),
                           14'($urandom_range(0, 30))};
            end
            if ($urandom_range(0, 59) == 0) begin fw = 1; fw_data = 16'($urandom); end
            if ($urandom_range(0, 299) == 0) hcr = 1;
            if ($urandom_range(0, 99) == 0) eo = 1;
            tick("R7 remaining random");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule